// File: doc/BRIEF.md
# Prioritized interrupt level selector

This block sits in front of a processor core and decides which interrupt level the core is asked to take. It combines fifteen usable external level requests with a software-interrupt register and picks the highest pending level. Two timer-match bits in that register are not levels of their own; either one raises level 14. The choice is then filtered by the core's current priority threshold, by a global interrupt enable, and by a nesting check against the trap already being serviced.

The output is a registered hard-interrupt request plus an interrupt index formed from the external-interrupt trap type base (0x40) with the selected level in bits [3:0]. When nothing at all is pending, the request drops and the index returns to zero. The software register is written through separate set and clear strobes, and any set strobe produces a one-cycle wake pulse so a halted core resumes and the selection is evaluated again.

Top module: `irq_level_sel`

## Requirements
- R1: The soft register (17 bits) takes `(old & ~soft_clr_i) | soft_set_i` on each clock edge, so a bit named by both strobes ends up set; `soft_o` shows the register.
- R2: The pending vector is `ext_lvl_i` ORed with soft bits [15:1]; soft bit 0 (tick match) and soft bit 16 (system-tick match) never set a level at their own position.
- R3: While soft bit 0 or soft bit 16 is set, level 14 is pending.
- R4: When the pending vector is zero, the next edge drives `irq_req_o` to 0 and `irq_idx_o` to 0.
- R5: With pending levels present and `ie_i` high, the candidate is the highest pending level strictly greater than `thr_i`; if no pending level exceeds `thr_i`, request and index hold.
- R6: A raised index equals 0x40 with the selected level in bits [3:0].
- R7: While `ie_i` is low and something is pending, request and index hold their values.
- R8: While `tl_i` is nonzero and `cur_tt_i` is greater than the candidate index, request and index hold; an equal trap type does not block.
- R9: A candidate that passes all filters and differs from the stored index is stored and `irq_req_o` is set; otherwise the request keeps its value until R4 clears it.
- R10: Level 0 never produces a request: an input on `ext_lvl_i[0]` alone counts as nothing pending.
- R11: `wake_o` is high for the cycle after any cycle in which `soft_set_i` is nonzero.
- R12: Reset (active-low, asynchronous) clears the soft register, `wake_o`, `irq_req_o` and `irq_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl_i | input | 16 | External level requests, bit n = level n |
| soft_set_i | input | 17 | Set strobes for the soft register |
| soft_clr_i | input | 17 | Clear strobes for the soft register |
| thr_i | input | 4 | Processor priority threshold |
| ie_i | input | 1 | Global interrupt enable |
| tl_i | input | 3 | Current trap nesting level |
| cur_tt_i | input | 9 | Trap type currently serviced |
| irq_req_o | output | 1 | Hard-interrupt request (registered) |
| irq_idx_o | output | 9 | Interrupt index (registered) |
| soft_o | output | 17 | Soft register contents |
| wake_o | output | 1 | One-cycle wake pulse after a set strobe |

## Verification
Inputs on `ext_lvl_i`, `thr_i`, `ie_i`, `tl_i` and `cur_tt_i` reach `irq_req_o`/`irq_idx_o` at the first clock edge after they are applied, while a soft strobe reaches `soft_o` and `wake_o` at that first edge and the request path only at the second, because the selection reads the registered soft bits. The bench drives inputs on the falling edge and its behavioural model advances on the rising edge from the same inputs, so the comparison taken a few nanoseconds after each rising edge sees exactly the one- and two-cycle latencies above. A handful of constant checks at chosen points pin the expected index values independently of the model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    // Decision taken by the selector for the next cycle
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_RAISE = 2'd2
    } sel_act_t;

endpackage

// File: rtl/soft_int_reg.sv
module soft_int_reg #(
    parameter int unsigned SOFT_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SOFT_W-1:0] set_i,
    input  logic [SOFT_W-1:0] clr_i,
    output logic [SOFT_W-1:0] soft_o,
    output logic              wake_o
);

    typedef struct packed {
        logic [SOFT_W-1:0] bits;
        logic              wake;
    } soft_st_t;

    soft_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
        st_d.wake = |set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign soft_o = st_q.bits;
    assign wake_o = st_q.wake;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((soft_o & $past(set_i)) == $past(set_i))); // R1
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((soft_o & $past(clr_i & ~set_i)) == '0)); // R1
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> wake_o); // R11

endmodule

// File: rtl/pend_fold.sv
module pend_fold #(
    parameter int unsigned LEVELS    = 16,
    parameter int unsigned TIMER_LVL = 14,
    parameter int unsigned SOFT_W    = LEVELS + 1
) (
    input  logic [LEVELS-1:0] ext_i,
    input  logic [SOFT_W-1:0] soft_i,
    output logic [LEVELS-1:0] pend_o
);

    localparam int unsigned TICK_BIT  = 0;
    localparam int unsigned STICK_BIT = LEVELS;

    logic timer_hit;

    assign timer_hit = soft_i[TICK_BIT] | soft_i[STICK_BIT];

    always_comb begin
        pend_o    = ext_i | soft_i[LEVELS-1:0];
        // level 0 and the tick-match position carry no request
        pend_o[0] = 1'b0;
        if (timer_hit) begin
            pend_o[TIMER_LVL] = 1'b1;
        end
    end

endmodule

// File: rtl/lvl_pick.sv
module lvl_pick #(
    parameter int unsigned LEVELS = 16,
    parameter int unsigned LVL_W  = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] pend_i,
    input  logic [LVL_W-1:0]  thr_i,
    output logic              hit_o,
    output logic [LVL_W-1:0]  lvl_o
);

    logic [LEVELS-1:0] qual;

    for (genvar g = 0; g < LEVELS; g++) begin : g_qual
        assign qual[g] = pend_i[g] && (LVL_W'(g) > thr_i);
    end

    // ascending scan, the last hit is the highest qualified level
    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (qual[i]) begin
                lvl_o = LVL_W'(i);
            end
        end
    end

    assign hit_o = |qual;

endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irq_sel_pkg::*;
#(
    parameter int unsigned       LEVELS      = 16,
    parameter int unsigned       TT_W        = 9,
    parameter int unsigned       TL_W        = 3,
    parameter logic [TT_W-1:0]   TT_EXT_BASE = 9'h040,
    parameter int unsigned       TIMER_LVL   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         ext_lvl_i,
    input  logic [16:0]         soft_set_i,
    input  logic [16:0]         soft_clr_i,
    input  logic [3:0]          thr_i,
    input  logic                ie_i,
    input  logic [2:0]          tl_i,
    input  logic [8:0]          cur_tt_i,
    output logic                irq_req_o,
    output logic [8:0]          irq_idx_o,
    output logic [16:0]         soft_o,
    output logic                wake_o
);

    localparam int unsigned    LVL_W  = $clog2(LEVELS);
    localparam int unsigned    SOFT_W = LEVELS + 1;
    localparam logic [TT_W-1:0] TT_TOP = TT_EXT_BASE | TT_W'(LEVELS - 1);

    typedef struct packed {
        logic            req;
        logic [TT_W-1:0] idx;
    } sel_st_t;

    logic [SOFT_W-1:0] soft_q;
    logic [LEVELS-1:0] pend;
    logic              pick_hit;
    logic [LVL_W-1:0]  pick_lvl;
    logic [TT_W-1:0]   cand_idx;
    logic              nest_block;
    sel_act_t          act;
    sel_st_t           st_d, st_q;

    soft_int_reg #(
        .SOFT_W (SOFT_W)
    ) u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (soft_set_i),
        .clr_i  (soft_clr_i),
        .soft_o (soft_q),
        .wake_o (wake_o)
    );

    pend_fold #(
        .LEVELS    (LEVELS),
        .TIMER_LVL (TIMER_LVL),
        .SOFT_W    (SOFT_W)
    ) u_fold (
        .ext_i  (ext_lvl_i),
        .soft_i (soft_q),
        .pend_o (pend)
    );

    lvl_pick #(
        .LEVELS (LEVELS),
        .LVL_W  (LVL_W)
    ) u_pick (
        .pend_i (pend),
        .thr_i  (thr_i),
        .hit_o  (pick_hit),
        .lvl_o  (pick_lvl)
    );

    assign cand_idx   = TT_EXT_BASE | TT_W'(pick_lvl);
    assign nest_block = (tl_i != '0) && (cur_tt_i > cand_idx);

    always_comb begin
        act  = ACT_HOLD;
        st_d = st_q;
        if (pend == '0) begin
            act = ACT_CLEAR;
        end else if (ie_i && pick_hit && !nest_block && (cand_idx != st_q.idx)) begin
            act = ACT_RAISE;
        end
        case (act)
            ACT_CLEAR: begin
                st_d.req = 1'b0;
                st_d.idx = '0;
            end
            ACT_RAISE: begin
                st_d.req = 1'b1;
                st_d.idx = cand_idx;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req_o = st_q.req;
    assign irq_idx_o = st_q.idx;
    assign soft_o    = soft_q;

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (!irq_req_o && irq_idx_o == '0)); // R4
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_i && pend != '0) |=> ($stable(irq_req_o) && $stable(irq_idx_o))); // R7
    AST_NEST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_i != '0 && cur_tt_i > TT_TOP && pend != '0) |=> $stable(irq_idx_o)); // R8
    AST_IDX_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> ((irq_idx_o & ~TT_W'(LEVELS - 1)) == TT_EXT_BASE
                       && irq_idx_o[LVL_W-1:0] != '0)); // R6
    AST_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_idx_o != $past(irq_idx_o) && irq_idx_o != '0)
            |-> (irq_idx_o[LVL_W-1:0] > $past(thr_i))); // R5
    AST_LVL0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_lvl_i == 16'h0001 && soft_q == '0) |=> !irq_req_o); // R10

endmodule

// File: tb/irq_level_sel_tb.sv
module irq_level_sel_tb;

    logic        clk;
    logic        rst_n;
    logic [15:0] ext_lvl_i;
    logic [16:0] soft_set_i;
    logic [16:0] soft_clr_i;
    logic [3:0]  thr_i;
    logic        ie_i;
    logic [2:0]  tl_i;
    logic [8:0]  cur_tt_i;
    logic        irq_req_o;
    logic [8:0]  irq_idx_o;
    logic [16:0] soft_o;
    logic        wake_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase    = "R12";

    irq_level_sel u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_lvl_i  (ext_lvl_i),
        .soft_set_i (soft_set_i),
        .soft_clr_i (soft_clr_i),
        .thr_i      (thr_i),
        .ie_i       (ie_i),
        .tl_i       (tl_i),
        .cur_tt_i   (cur_tt_i),
        .irq_req_o  (irq_req_o),
        .irq_idx_o  (irq_idx_o),
        .soft_o     (soft_o),
        .wake_o     (wake_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // behavioural reference model
    logic [16:0] m_soft;
    logic        m_wake;
    logic        m_req;
    logic [8:0]  m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_soft = '0;
            m_wake = 1'b0;
            m_req  = 1'b0;
            m_idx  = '0;
        end else begin
            int pend_bits [16];
            int any;
            int best;
            int cand;
            any  = 0;
            best = -1;
            for (int i = 1; i < 16; i++) begin
                pend_bits[i] = (ext_lvl_i[i] || (m_soft[i] && i != 0)) ? 1 : 0;
            end
            if (m_soft[0] || m_soft[16]) pend_bits[14] = 1;
            for (int i = 1; i < 16; i++) if (pend_bits[i] != 0) any = 1;
            for (int i = 15; i > 0; i--) begin
                if (best < 0 && i > int'(thr_i) && pend_bits[i] != 0) best = i;
            end
            if (any == 0) begin
                m_req = 1'b0;
                m_idx = '0;
            end else if (ie_i && best > 0) begin
                cand = 64 + best;
                if (!(tl_i != 0 && int'(cur_tt_i) > cand) && cand != int'(m_idx)) begin
                    m_req = 1'b1;
                    m_idx = 9'(cand);
                end
            end
            m_soft = (m_soft & ~soft_clr_i) | soft_set_i;
            m_wake = (soft_set_i != '0);
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    // compare every cycle, shortly after the rising edge
    always @(posedge clk) begin
        #3;
        chk("req",  32'(irq_req_o), 32'(m_req));
        chk("idx",  32'(irq_idx_o), 32'(m_idx));
        chk("soft", 32'(soft_o),    32'(m_soft));
        chk("wake", 32'(wake_o),    32'(m_wake));
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(logic [16:0] s, logic [16:0] c);
        @(negedge clk);
        soft_set_i = s;
        soft_clr_i = c;
        @(negedge clk);
        soft_set_i = '0;
        soft_clr_i = '0;
    endtask

    task automatic expect_idx(string tag, logic [8:0] exp_idx, logic exp_req);
        string saved;
        saved = phase;
        phase = tag;
        chk("fixed idx", 32'(irq_idx_o), 32'(exp_idx));
        chk("fixed req", 32'(irq_req_o), 32'(exp_req));
        phase = saved;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_lvl_i = '0; soft_set_i = '0; soft_clr_i = '0;
        thr_i = '0; ie_i = 1'b1; tl_i = '0; cur_tt_i = '0;
        cycles(3);
        expect_idx("R12", 9'h000, 1'b0);
        rst_n = 1'b1;
        cycles(2);

        phase = "R6";  ext_lvl_i = 16'h0020; cycles(2);
        expect_idx("R6", 9'h045, 1'b1);
        phase = "R5";  ext_lvl_i = 16'h0220; cycles(2);
        expect_idx("R5", 9'h049, 1'b1);
        phase = "R5";  thr_i = 4'd10; cycles(2);
        expect_idx("R5", 9'h049, 1'b1);
        phase = "R9";  ext_lvl_i = 16'h1220; cycles(2);
        expect_idx("R9", 9'h04C, 1'b1);
        phase = "R4";  thr_i = 4'd0; ext_lvl_i = '0; cycles(2);
        expect_idx("R4", 9'h000, 1'b0);

        phase = "R3";  strobe(17'h00001, '0); cycles(2);
        expect_idx("R3", 9'h04E, 1'b1);
        phase = "R2";  strobe(17'h10000, 17'h00001); cycles(2);
        expect_idx("R2", 9'h04E, 1'b1);
        phase = "R11"; strobe(17'h00008, 17'h10000); cycles(2);
        expect_idx("R2", 9'h043, 1'b1);
        phase = "R1";  strobe('0, 17'h1FFFF); cycles(2);
        expect_idx("R1", 9'h000, 1'b0);

        phase = "R10"; ext_lvl_i = 16'h0001; cycles(3);
        expect_idx("R10", 9'h000, 1'b0);
        phase = "R7";  ie_i = 1'b0; ext_lvl_i = 16'h0080; cycles(3);
        expect_idx("R7", 9'h000, 1'b0);
        phase = "R7";  ie_i = 1'b1; cycles(2);
        expect_idx("R7", 9'h047, 1'b1);

        phase = "R8";  tl_i = 3'd1; cur_tt_i = 9'h050; ext_lvl_i = 16'h0880; cycles(3);
        expect_idx("R8", 9'h047, 1'b1);
        phase = "R8";  cur_tt_i = 9'h04B; cycles(2);
        expect_idx("R8", 9'h04B, 1'b1);
        tl_i = '0; cur_tt_i = '0; ext_lvl_i = '0; cycles(2);

        phase = "R1";  strobe(17'h00040, 17'h00040); cycles(2);
        expect_idx("R1", 9'h046, 1'b1);
        phase = "R1";  strobe(17'h00004, 17'h00040); cycles(2);
        expect_idx("R1", 9'h042, 1'b1);
        strobe('0, 17'h1FFFF); cycles(3);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule